// File: doc/BRIEF.md
# Interrupt Status, Mask and Mailbox Register File

This block is a small bank of processor-visible registers, each with its own write rule. An interrupt status register collects pulses from hardware sources. The processor acknowledges these by writing ones to the bits it wants to clear. An interrupt mask register is never loaded directly. Each mask write flips the mask bits that the written value marks. The block ORs together every status bit that is enabled by its mask bit and drives the result as the processor interrupt line.

A shared flag word serves as a mailbox between two processors. It is reached through two write addresses: one ORs the written value into the word, and the other clears the bits the written value marks. A control register lets the processor send a one-cycle interrupt pulse or a one-cycle reset pulse to a remote processor, and it also keeps one plain stored bit. A command register keeps whatever is written to it, except that its busy bit is always stored as zero.

The register word offsets, compared against the full address, are:

| Offset | Register |
|--------|----------|
| 0 | status |
| 1 | mask |
| 2 | flag-set |
| 3 | flag-clear |
| 4 | control |
| 5 | command |

Reads are combinational from `rd_addr`.

Top module: `irq_mbox_regs`

## Requirements
- R1: After reset, every register reads as zero, and `cpu_irq`, `remote_irq_pulse` and `remote_rst_pulse` are all low.
- R2: A write to offset 0 clears each status bit whose written bit is 1. Status bits written as 0 keep their value.
- R3: A high bit on `hw_src` sets the matching status bit at the next clock edge. If a source pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: A write to offset 1 XORs bits 15:0 of the written value into the 16-bit mask. Bits 31:16 of the written value have no effect.
- R5: `cpu_irq` is high exactly when some status bit and its mask bit are both 1. It is re-evaluated in the cycle after any status or mask change.
- R6: A write to offset 2 ORs the written value into the flag word.
- R7: A write to offset 3 ANDs the flag word with the complement of the written value. Reads at either offset 2 or offset 3 return the flag word.
- R8: A write to offset 4 with bit 18 set drives `remote_irq_pulse` high for exactly the one cycle after the write edge.
- R9: A write to offset 4 with bit 19 set drives `remote_rst_pulse` high for exactly the one cycle after the write edge.
- R10: Control bit 8 takes the written bit 8 on every write to offset 4. A read at offset 4 returns only bit 8; all other bits read as zero.
- R11: A write to offset 5 stores the written value with bit 31 (the busy bit) forced to 0.
- R12: Status and mask read back zero-extended to 32 bits. Reads at unmapped offsets (6 and above) return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_addr | input | ADDR_W (4) | Word offset of the write |
| wr_data | input | DATA_W (32) | Write value |
| rd_addr | input | ADDR_W (4) | Word offset of the read |
| rd_data | output | DATA_W (32) | Read value (combinational) |
| hw_src | input | IRQ_W (16) | Hardware interrupt source pulses, one per status bit |
| cpu_irq | output | 1 | Combined masked interrupt to the processor |
| remote_irq_pulse | output | 1 | One-cycle interrupt pulse to the remote processor |
| remote_rst_pulse | output | 1 | One-cycle reset pulse to the remote side |

## Verification
The hardest case to reach is a clearing write and a source pulse that land on the same status bit in the same cycle. A stimulus entry therefore drives a status write together with `hw_src` on an overlapping bit. It then reads the status back to confirm that the bit stayed set while a neighbouring bit was cleared. The mask is only reachable through toggling, so every mask value the bench relies on is built up from XOR writes whose running result has been worked out in advance.

// File: rtl/irq_mbox_pkg.sv
package irq_mbox_pkg;
  // register word offsets
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_MASK   = 1;
  localparam int unsigned OFS_FSET   = 2;
  localparam int unsigned OFS_FCLR   = 3;
  localparam int unsigned OFS_CTRL   = 4;
  localparam int unsigned OFS_CMD    = 5;
  localparam int unsigned NUM_REGS   = 6;

  // one-hot write decode indices
  typedef enum logic [2:0] {
    HIT_STATUS = 3'd0,
    HIT_MASK   = 3'd1,
    HIT_FSET   = 3'd2,
    HIT_FCLR   = 3'd3,
    HIT_CTRL   = 3'd4,
    HIT_CMD    = 3'd5
  } hit_idx_e;
endpackage

// File: rtl/irq_status_mask.sv
module irq_status_mask #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] wlow,
  input  logic [IRQ_W-1:0] src,
  output logic [IRQ_W-1:0] status_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);
  // clear first, then set: a source pulse beats a clearing write
  function automatic logic [IRQ_W-1:0] status_next(
    input logic [IRQ_W-1:0] cur, input logic [IRQ_W-1:0] clr, input logic [IRQ_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [IRQ_W-1:0] mask_next(
    input logic [IRQ_W-1:0] cur, input logic [IRQ_W-1:0] flip);
    return cur ^ flip;
  endfunction

  logic [IRQ_W-1:0] clr_vec;
  logic [IRQ_W-1:0] pending;

  assign clr_vec = stat_wr ? wlow : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_next(status_q, clr_vec, src);
      if (mask_wr) mask_q <= mask_next(mask_q, wlow);
    end
  end

  assign pending = status_q & mask_q;
  assign irq     = |pending;

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && src == '0) |=> ((status_q & $past(wlow)) == '0));
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && src == '0) |=> ((status_q & ~$past(wlow)) == ($past(status_q) & ~$past(wlow))));
  a_r3_src_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> ((status_q & $past(src)) == $past(src)));
  a_r4_mask_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == ($past(mask_q) ^ $past(wlow))));
  a_r5_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flags_q
);
  function automatic logic [DATA_W-1:0] flags_next(
    input logic [DATA_W-1:0] cur, input logic do_set, input logic do_clr,
    input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = cur;
    if (do_set) r = r | v;
    if (do_clr) r = r & ~v;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_next(flags_q, set_wr, clr_wr, wdata);
  end

  a_r6_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((flags_q & $past(wdata)) == $past(wdata)));
  a_r7_clr_ands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((flags_q & $past(wdata)) == '0));
  a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr || set_wr) |=> ((flags_q & ~$past(wdata)) == ($past(flags_q) & ~$past(wdata))));
endmodule

// File: rtl/remote_ctrl.sv
module remote_ctrl #(
  parameter int DATA_W   = 32,
  parameter int KEEP_BIT = 8,
  parameter int IRQ_BIT  = 18,
  parameter int RST_BIT  = 19,
  parameter int BUSY_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              keep_q,
  output logic              irq_pulse,
  output logic              rst_pulse,
  output logic [DATA_W-1:0] cmd_q
);
  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

  function automatic logic [DATA_W-1:0] cmd_clean(input logic [DATA_W-1:0] v);
    return v & ~BUSY_MASK;
  endfunction

  logic fire_irq, fire_rst;
  assign fire_irq = ctrl_wr && wdata[IRQ_BIT];
  assign fire_rst = ctrl_wr && wdata[RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q    <= 1'b0;
      irq_pulse <= 1'b0;
      rst_pulse <= 1'b0;
      cmd_q     <= '0;
    end else begin
      irq_pulse <= fire_irq;
      rst_pulse <= fire_rst;
      if (ctrl_wr) keep_q <= wdata[KEEP_BIT];
      if (cmd_wr)  cmd_q  <= cmd_clean(wdata);
    end
  end

  a_r8_irq_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ctrl_wr && wdata[IRQ_BIT]));
  a_r9_rst_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(ctrl_wr && wdata[RST_BIT]));
  a_r10_keep_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (keep_q == $past(wdata[KEEP_BIT])));
  a_r11_cmd_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_q[BUSY_BIT-1:0] == $past(wdata[BUSY_BIT-1:0]) && !cmd_q[BUSY_BIT]));
endmodule

// File: rtl/irq_mbox_regs.sv
module irq_mbox_regs
  import irq_mbox_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IRQ_W-1:0]  hw_src,
  output logic              cpu_irq,
  output logic              remote_irq_pulse,
  output logic              remote_rst_pulse
);
  localparam int KEEP_BIT = 8;

  logic [NUM_REGS-1:0] wr_hit;
  logic [IRQ_W-1:0]    status_q, mask_q;
  logic [DATA_W-1:0]   flags_q, cmd_q;
  logic                keep_q;

  // one strobe per mapped offset
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

  irq_status_mask #(.IRQ_W(IRQ_W)) u_sm (
    .clk(clk), .rst_n(rst_n),
    .stat_wr(wr_hit[HIT_STATUS]), .mask_wr(wr_hit[HIT_MASK]),
    .wlow(wr_data[IRQ_W-1:0]), .src(hw_src),
    .status_q(status_q), .mask_q(mask_q), .irq(cpu_irq)
  );

  mbox_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_wr(wr_hit[HIT_FSET]), .clr_wr(wr_hit[HIT_FCLR]),
    .wdata(wr_data), .flags_q(flags_q)
  );

  remote_ctrl #(.DATA_W(DATA_W), .KEEP_BIT(KEEP_BIT)) u_rc (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_hit[HIT_CTRL]), .cmd_wr(wr_hit[HIT_CMD]),
    .wdata(wr_data), .keep_q(keep_q),
    .irq_pulse(remote_irq_pulse), .rst_pulse(remote_rst_pulse), .cmd_q(cmd_q)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFS_STATUS): rd_data = DATA_W'(status_q);
      ADDR_W'(OFS_MASK):   rd_data = DATA_W'(mask_q);
      ADDR_W'(OFS_FSET),
      ADDR_W'(OFS_FCLR):   rd_data = flags_q;
      ADDR_W'(OFS_CTRL):   rd_data[KEEP_BIT] = keep_q;
      ADDR_W'(OFS_CMD):    rd_data = cmd_q;
      default:             rd_data = '0;
    endcase
  end

  a_r12_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  a_r12_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit == '0) |=> ($stable(flags_q) && $stable(cmd_q) && $stable(mask_q) && $stable(keep_q)));
  a_r1_pulses_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (!remote_irq_pulse && !remote_rst_pulse));
endmodule

// File: tb/test_irq_mbox_regs.sv
module test_irq_mbox_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [15:0] src;
    logic [3:0]  ca;
    logic [31:0] exp;
    logic        eirq;
    logic [7:0]  req;
  } vec_t;

  // write, source pulses, readback offset, expected read, expected irq, requirement
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h0000_0000, 16'h00F0, 4'd0, 32'h0000_00F0, 1'b0, 8'd3},  // R3 sources set
    '{4'd1, 32'hFFFF_0030, 16'h0000, 4'd1, 32'h0000_0030, 1'b1, 8'd4},  // R4 upper ignored
    '{4'd0, 32'h0000_0010, 16'h0000, 4'd0, 32'h0000_00E0, 1'b1, 8'd2},  // R2 w1c
    '{4'd1, 32'h0000_0020, 16'h0000, 4'd1, 32'h0000_0010, 1'b0, 8'd5},  // R5 irq drops
    '{4'd0, 32'h0000_00C0, 16'h0040, 4'd0, 32'h0000_0060, 1'b0, 8'd3},  // R3 set wins
    '{4'd2, 32'hA500_0011, 16'h0000, 4'd2, 32'hA500_0011, 1'b0, 8'd6},  // R6
    '{4'd2, 32'h0000_F000, 16'h0000, 4'd3, 32'hA500_F011, 1'b0, 8'd6},  // R6 via R7 addr
    '{4'd3, 32'h8100_F001, 16'h0000, 4'd2, 32'h2400_0010, 1'b0, 8'd7},  // R7
    '{4'd4, 32'h0000_0100, 16'h0000, 4'd4, 32'h0000_0100, 1'b0, 8'd10}, // R10 set
    '{4'd4, 32'hFFF3_FEFF, 16'h0000, 4'd4, 32'h0000_0000, 1'b0, 8'd10}, // R10 clear
    '{4'd5, 32'hFFFF_1234, 16'h0000, 4'd5, 32'h7FFF_1234, 1'b0, 8'd11}, // R11
    '{4'd7, 32'hFFFF_FFFF, 16'h0000, 4'd7, 32'h0000_0000, 1'b0, 8'd12}  // R12
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] hw_src = '0;
  logic cpu_irq, remote_irq_pulse, remote_rst_pulse;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mbox_regs i_irq_mbox_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hw_src(hw_src), .cpu_irq(cpu_irq),
    .remote_irq_pulse(remote_irq_pulse), .remote_rst_pulse(remote_rst_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [15:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; hw_src = s;
    @(negedge clk);
    wr_en = 1'b0; hw_src = '0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_check("R1 reset read", 4'(a), 32'h0);
    check("R1 irq", 32'(cpu_irq), 32'h0);
    check("R1 pulses", 32'({remote_irq_pulse, remote_rst_pulse}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].wa, VECS[i].wd, VECS[i].src);
      rd_addr = VECS[i].ca; #1;
      check($sformatf("R%0d vec%0d read", VECS[i].req, i), rd_data, VECS[i].exp);
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), 32'(cpu_irq), 32'(VECS[i].eirq));
    end

    // R12 unmapped write left everything intact
    rd_check("R12 flags intact", 4'd3, 32'h2400_0010);
    rd_check("R12 mask intact", 4'd1, 32'h0000_0010);

    // R8 remote interrupt pulse: high for one cycle after the write edge
    do_write(4'd4, 32'h0004_0000, 16'h0);
    #1 check("R8 irq pulse high", 32'({remote_irq_pulse, remote_rst_pulse}), 32'h2);
    @(negedge clk); #1 check("R8 irq pulse gone", 32'(remote_irq_pulse), 32'h0);

    // R9 remote reset pulse
    do_write(4'd4, 32'h0008_0000, 16'h0);
    #1 check("R9 rst pulse high", 32'({remote_irq_pulse, remote_rst_pulse}), 32'h1);
    @(negedge clk); #1 check("R9 rst pulse gone", 32'(remote_rst_pulse), 32'h0);

    // R3 same bit clear and set together; R2 neighbour bit cleared
    do_write(4'd0, 32'h0000_0060, 16'h0040);
    rd_check("R3 collision", 4'd0, 32'h0000_0040);

    // R5 source on enabled bit raises irq one cycle later, mask toggle drops it
    do_write(4'd0, 32'h0, 16'h0010);
    #1 check("R5 irq raised", 32'(cpu_irq), 32'h1);
    do_write(4'd1, 32'h0000_0010, 16'h0);
    #1 check("R5 irq after mask toggle", 32'(cpu_irq), 32'h0);
    do_write(4'd0, 32'hFFFF_FFFF, 16'h0);
    rd_check("R2 clear all", 4'd0, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule